// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block is the device-side front end of a small NAND flash memory. It watches an 8-bit multiplexed I/O bus together with chip enable, a write strobe and two latch enables. On each rising edge of the write strobe while chip enable is low, it classifies the byte as a command, an address byte or a data byte. It then assembles the column and row address, follows the one- and two-command sequences, and issues one decoded operation request carrying the latched address.

The memory behind it has 8192 rows (pages) of 264 columns. Columns 0 to 255 form the main field and columns 256 to 263 the spare field. Sixteen consecutive pages make one erase block, which gives 512 blocks. The block also numbers each accepted program data byte with its target column, so a page buffer can store it directly. It flags sequence errors when a confirm command arrives without its matching setup command.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A byte is taken only on a rising edge of `we_n` (low, then high on the next clock sample) while `ce_n` is low. An edge with `ce_n` high has no effect.
- R2: A byte with `cle`=1 and `ale`=0 is a command. A byte with `ale`=1 and `cle`=0 is an address byte. A byte with both low is data. A byte with both high is discarded.
- R3: Command 00h followed by three address bytes (column, row low, row high) issues a main read. Its column is the column byte, and its row is {row-high[4:0], row-low}; the upper 3 bits of the row-high byte are dropped.
- R4: Command 50h followed by the same three address bytes issues a spare read. Its column is 256 plus bits [2:0] of the column byte.
- R5: Command 60h takes two address bytes (row low, row high). The erase request is issued only on the confirm command D0h, and its row has bits [3:0] cleared, which gives the first page of the block.
- R6: Command 80h, three address bytes, data bytes, then 10h issue a program request carrying the column and row given after 80h.
- R7: A D0h outside an erase sequence, or a 10h outside a program sequence, issues no request and pulses `seq_err` for one cycle.
- R8: Command FFh is accepted at any point. It issues a reset request, abandons any partly entered sequence and clears the latched column and row to zero.
- R9: In a program sequence, once all three address bytes are in, each data byte is reported on `data_valid` with its column. The first byte goes to the latched column and each later byte to the next column, up to column 263. Bytes beyond column 263 are dropped.
- R10: Commands 90h (read ID) and 70h (read status) issue their requests at once. 70h leaves a sequence in progress untouched; 90h ends it.
- R11: `op_kind` codes: 1 main read, 2 spare read, 3 read ID, 4 reset, 5 program, 6 erase, 7 status. `op_valid` is a one-cycle pulse and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe; byte captured on its rising edge |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io_in | input | 8 | Multiplexed command/address/data byte |
| op_valid | output | 1 | One-cycle pulse: decoded request present |
| op_kind | output | 3 | Request kind (codes in R11) |
| op_col | output | 9 | Column of the request |
| op_row | output | 13 | Row (page) of the request |
| data_valid | output | 1 | One-cycle pulse: program data byte accepted |
| data_col | output | 9 | Target column of the accepted data byte |
| data_byte | output | 8 | Accepted data byte |
| seq_err | output | 1 | One-cycle pulse: orphan confirm command |

## Verification
The bench targets the spare-column offset. A decoder that passes the column byte straight through reports a spare read at a main column. The erase request must stay silent until D0h and must come back with its page bits cleared; a design that fires on the last row byte, or keeps the page bits, shows up in the captured request. The program data counter is started near the end of the spare field and driven past column 263; an off-by-one bound gives one data pulse too many or too few. Orphan confirms, a reset in the middle of an erase sequence, and a status command in the middle of a program sequence check that the sequence state is kept or dropped exactly as required.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

    localparam int IO_W        = 8;
    localparam int COL_W       = 9;
    localparam int ROW_W       = 13;
    localparam int PAGE_W      = 4;
    localparam int MAIN_COLS   = 256;
    localparam int SPARE_COLS  = 8;
    localparam int LAST_COL    = MAIN_COLS + SPARE_COLS - 1;
    localparam int ROW_HI_W    = ROW_W - IO_W;
    localparam int SPARE_SEL_W = $clog2(SPARE_COLS);
    localparam int KIND_W      = 3;

    localparam logic [IO_W-1:0] CODE_READ_MAIN  = 8'h00;
    localparam logic [IO_W-1:0] CODE_READ_SPARE = 8'h50;
    localparam logic [IO_W-1:0] CODE_READ_ID    = 8'h90;
    localparam logic [IO_W-1:0] CODE_RESET      = 8'hFF;
    localparam logic [IO_W-1:0] CODE_LOAD_SETUP = 8'h80;
    localparam logic [IO_W-1:0] CODE_LOAD_GO    = 8'h10;
    localparam logic [IO_W-1:0] CODE_WIPE_SETUP = 8'h60;
    localparam logic [IO_W-1:0] CODE_WIPE_GO    = 8'hD0;
    localparam logic [IO_W-1:0] CODE_STATUS     = 8'h70;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE       = 3'd0,
        KIND_READ_MAIN  = 3'd1,
        KIND_READ_SPARE = 3'd2,
        KIND_READ_ID    = 3'd3,
        KIND_RESET      = 3'd4,
        KIND_PROGRAM    = 3'd5,
        KIND_ERASE      = 3'd6,
        KIND_STATUS     = 3'd7
    } op_kind_e;

    typedef enum logic [2:0] {
        MODE_IDLE, MODE_READ, MODE_SPARE, MODE_PROG, MODE_ERASE
    } seq_mode_e;

    typedef enum logic [1:0] {
        SLOT_COL    = 2'd0,
        SLOT_ROW_LO = 2'd1,
        SLOT_ROW_HI = 2'd2,
        SLOT_FULL   = 2'd3
    } addr_slot_e;

    typedef struct packed {
        op_kind_e               kind;
        logic [COL_W-1:0]       col;
        logic [ROW_W-1:0]       row;
    } op_req_t;

    function automatic logic [COL_W-1:0] map_column(input logic [IO_W-1:0] b,
                                                    input logic spare);
        if (spare)
            return COL_W'(MAIN_COLS) + COL_W'(b[SPARE_SEL_W-1:0]);
        return COL_W'(b);
    endfunction

    function automatic logic [ROW_W-1:0] block_base(input logic [ROW_W-1:0] r);
        return {r[ROW_W-1:PAGE_W], {PAGE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
    import nand_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            cle,
    input  logic            ale,
    output logic            cmd_stb,
    output logic            addr_stb,
    output logic            data_stb
);
    logic we_prev;
    logic take;

    always_ff @(posedge clk) begin
        if (rst) we_prev <= 1'b1;
        else     we_prev <= we_n;
    end

    assign take     = !we_prev && we_n && !ce_n;
    assign cmd_stb  = take &&  cle && !ale;
    assign addr_stb = take && !cle &&  ale;
    assign data_stb = take && !cle && !ale;
endmodule

// File: rtl/nand_addr_assembler.sv
module nand_addr_assembler
    import nand_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               begin_col,
    input  logic               begin_row,
    input  logic               addr_en,
    input  logic               spare_sel,
    input  logic               data_adv,
    input  logic [IO_W-1:0]    byte_in,
    output logic [COL_W-1:0]   col,
    output logic [ROW_W-1:0]   row,
    output logic [COL_W-1:0]   next_col,
    output logic               addr_done
);
    addr_slot_e slot;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slot     <= SLOT_FULL;
            col      <= '0;
            row      <= '0;
            next_col <= '0;
        end else if (begin_col || begin_row) begin
            slot     <= begin_col ? SLOT_COL : SLOT_ROW_LO;
            col      <= '0;
            row      <= '0;
            next_col <= '0;
        end else begin
            if (addr_en) begin
                case (slot)
                    SLOT_COL: begin
                        col      <= map_column(byte_in, spare_sel);
                        next_col <= map_column(byte_in, spare_sel);
                        slot     <= SLOT_ROW_LO;
                    end
                    SLOT_ROW_LO: begin
                        row[IO_W-1:0] <= byte_in;
                        slot          <= SLOT_ROW_HI;
                    end
                    SLOT_ROW_HI: begin
                        row[ROW_W-1:IO_W] <= byte_in[ROW_HI_W-1:0];
                        slot              <= SLOT_FULL;
                    end
                    default: ;
                endcase
            end
            if (data_adv) next_col <= next_col + 1'b1;
        end
    end

    assign addr_done = (slot == SLOT_FULL);
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_stb,
    input  logic               addr_stb,
    input  logic               data_stb,
    input  logic [IO_W-1:0]    byte_in,
    input  logic [COL_W-1:0]   col,
    input  logic [ROW_W-1:0]   row,
    input  logic [COL_W-1:0]   next_col,
    input  logic               addr_done,
    output logic               clr,
    output logic               begin_col,
    output logic               begin_row,
    output logic               addr_en,
    output logic               spare_sel,
    output logic               data_adv,
    output logic               op_valid,
    output op_req_t            op_q,
    output logic               data_valid,
    output logic [COL_W-1:0]   data_col,
    output logic [IO_W-1:0]    data_byte,
    output logic               seq_err
);
    seq_mode_e mode;

    always_comb begin
        clr       = cmd_stb && (byte_in == CODE_RESET);
        begin_col = cmd_stb && (byte_in == CODE_READ_MAIN || byte_in == CODE_READ_SPARE ||
                                byte_in == CODE_LOAD_SETUP);
        begin_row = cmd_stb && (byte_in == CODE_WIPE_SETUP);
        addr_en   = addr_stb && (mode != MODE_IDLE);
        spare_sel = (mode == MODE_SPARE);
        data_adv  = data_stb && (mode == MODE_PROG) && addr_done &&
                    (next_col <= COL_W'(LAST_COL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= MODE_IDLE;
            op_valid   <= 1'b0;
            op_q       <= '{kind: KIND_NONE, col: '0, row: '0};
            data_valid <= 1'b0;
            data_col   <= '0;
            data_byte  <= '0;
            seq_err    <= 1'b0;
        end else begin
            op_valid   <= 1'b0;
            seq_err    <= 1'b0;
            data_valid <= 1'b0;
            if (cmd_stb) begin
                case (byte_in)
                    CODE_RESET: begin
                        mode     <= MODE_IDLE;
                        op_valid <= 1'b1;
                        op_q     <= '{kind: KIND_RESET, col: '0, row: '0};
                    end
                    CODE_READ_MAIN:  mode <= MODE_READ;
                    CODE_READ_SPARE: mode <= MODE_SPARE;
                    CODE_LOAD_SETUP: mode <= MODE_PROG;
                    CODE_WIPE_SETUP: mode <= MODE_ERASE;
                    CODE_READ_ID: begin
                        mode     <= MODE_IDLE;
                        op_valid <= 1'b1;
                        op_q     <= '{kind: KIND_READ_ID, col: col, row: row};
                    end
                    CODE_STATUS: begin
                        op_valid <= 1'b1;
                        op_q     <= '{kind: KIND_STATUS, col: col, row: row};
                    end
                    CODE_LOAD_GO: begin
                        if (mode == MODE_PROG) begin
                            mode     <= MODE_IDLE;
                            op_valid <= 1'b1;
                            op_q     <= '{kind: KIND_PROGRAM, col: col, row: row};
                        end else begin
                            seq_err <= 1'b1;
                        end
                    end
                    CODE_WIPE_GO: begin
                        if (mode == MODE_ERASE) begin
                            mode     <= MODE_IDLE;
                            op_valid <= 1'b1;
                            op_q     <= '{kind: KIND_ERASE, col: '0, row: block_base(row)};
                        end else begin
                            seq_err <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if ((mode == MODE_READ || mode == MODE_SPARE) && addr_done) begin
                mode     <= MODE_IDLE;
                op_valid <= 1'b1;
                op_q     <= '{kind: (mode == MODE_SPARE) ? KIND_READ_SPARE : KIND_READ_MAIN,
                              col: col, row: row};
            end
            if (data_adv) begin
                data_valid <= 1'b1;
                data_col   <= next_col;
                data_byte  <= byte_in;
            end
        end
    end
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
    import nand_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ce_n,
    input  logic               we_n,
    input  logic               cle,
    input  logic               ale,
    input  logic [7:0]         io_in,
    output logic               op_valid,
    output logic [2:0]         op_kind,
    output logic [8:0]         op_col,
    output logic [12:0]        op_row,
    output logic               data_valid,
    output logic [8:0]         data_col,
    output logic [7:0]         data_byte,
    output logic               seq_err
);
    logic             cmd_stb, addr_stb, data_stb;
    logic             clr, begin_col, begin_row, addr_en, spare_sel, data_adv, addr_done;
    logic [COL_W-1:0] col_q, next_col;
    logic [ROW_W-1:0] row_q;
    op_req_t          op_q;

    nand_bus_sampler u_sampler (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .cmd_stb(cmd_stb), .addr_stb(addr_stb), .data_stb(data_stb)
    );

    nand_addr_assembler u_addr (
        .clk(clk), .rst(rst), .clr(clr), .begin_col(begin_col), .begin_row(begin_row),
        .addr_en(addr_en), .spare_sel(spare_sel), .data_adv(data_adv), .byte_in(io_in),
        .col(col_q), .row(row_q), .next_col(next_col), .addr_done(addr_done)
    );

    nand_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb), .data_stb(data_stb),
        .byte_in(io_in), .col(col_q), .row(row_q), .next_col(next_col),
        .addr_done(addr_done), .clr(clr), .begin_col(begin_col), .begin_row(begin_row),
        .addr_en(addr_en), .spare_sel(spare_sel), .data_adv(data_adv),
        .op_valid(op_valid), .op_q(op_q), .data_valid(data_valid), .data_col(data_col),
        .data_byte(data_byte), .seq_err(seq_err)
    );

    assign op_kind = op_q.kind;
    assign op_col  = op_q.col;
    assign op_row  = op_q.row;
endmodule

// File: rtl/nand_cmd_decoder_chk.sv
module nand_cmd_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        ce_n,
    input logic        cle,
    input logic        ale,
    input logic        op_valid,
    input logic [2:0]  op_kind,
    input logic [8:0]  op_col,
    input logic [12:0] op_row,
    input logic        data_valid,
    input logic [8:0]  data_col,
    input logic        seq_err
);
    assert_data_from_bus_R1: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (!$past(ce_n) && !$past(cle) && !$past(ale)));

    assert_err_from_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> ($past(cle) && !$past(ale) && !$past(ce_n)));

    assert_main_col_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd1) |-> (op_col < 9'd256));

    assert_spare_col_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd2) |-> (op_col >= 9'd256 && op_col <= 9'd263));

    assert_erase_block_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd6) |-> (op_row[3:0] == 4'd0));

    assert_err_no_op_R7: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !op_valid);

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd4) |-> (op_col == 9'd0 && op_row == 13'd0));

    assert_data_limit_R9: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (data_col <= 9'd263));

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);
endmodule

bind nand_cmd_decoder nand_cmd_decoder_chk chk_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale),
    .op_valid(op_valid), .op_kind(op_kind), .op_col(op_col), .op_row(op_row),
    .data_valid(data_valid), .data_col(data_col), .seq_err(seq_err)
);

// File: tb/nand_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nand_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
    logic [7:0]  io_in = 8'h00;
    logic        op_valid, data_valid, seq_err;
    logic [2:0]  op_kind;
    logic [8:0]  op_col, data_col;
    logic [12:0] op_row;
    logic [7:0]  data_byte;

    int checks = 0, failures = 0;
    int ops = 0, errs = 0, datas = 0;
    int last_kind = 0, last_col = 0, last_row = 0, last_dcol = 0, last_dbyte = 0;

    always #2.5 clk = ~clk;

    nand_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io_in(io_in), .op_valid(op_valid), .op_kind(op_kind), .op_col(op_col),
        .op_row(op_row), .data_valid(data_valid), .data_col(data_col),
        .data_byte(data_byte), .seq_err(seq_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (op_valid) begin
                ops++; last_kind = op_kind; last_col = op_col; last_row = op_row;
            end
            if (seq_err) errs++;
            if (data_valid) begin
                datas++; last_dcol = data_col; last_dbyte = data_byte;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic c, input logic a, input logic [7:0] b,
                             input logic cen = 1'b0);
        @(negedge clk);
        cle = c; ale = a; io_in = b; ce_n = cen; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  bus_write(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  bus_write(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b);  bus_write(1'b0, 1'b0, b); endtask

    task automatic t_reset_state;
        chk("R11", "op_valid after reset", op_valid, 0);
        chk("R11", "data_valid after reset", data_valid, 0);
        chk("R7", "seq_err after reset", seq_err, 0);
    endtask

    task automatic t_read_main;
        int o = ops;
        cmd(8'h00); adr(8'h5A); adr(8'h34); adr(8'hF2);
        chk("R3", "main read count", ops - o, 1);
        chk("R11", "main read kind", last_kind, 1);
        chk("R3", "main read col", last_col, 'h5A);
        chk("R3", "main read row", last_row, 'h1234);
    endtask

    task automatic t_read_spare;
        int o = ops;
        cmd(8'h50); adr(8'hFD); adr(8'h01); adr(8'h00);
        chk("R4", "spare read count", ops - o, 1);
        chk("R4", "spare read kind", last_kind, 2);
        chk("R4", "spare read col", last_col, 261);
        chk("R4", "spare read row", last_row, 1);
    endtask

    task automatic t_ignored_strobes;
        int o = ops;
        bus_write(1'b1, 1'b0, 8'h90, 1'b1);
        chk("R1", "no op with ce_n high", ops - o, 0);
        bus_write(1'b1, 1'b1, 8'h90);
        chk("R2", "no op with cle and ale high", ops - o, 0);
        cmd(8'h90);
        chk("R10", "read ID fires", ops - o, 1);
        chk("R10", "read ID kind", last_kind, 3);
    endtask

    task automatic t_erase;
        int o = ops;
        cmd(8'h60); adr(8'h37); adr(8'h1F);
        chk("R5", "no erase before confirm", ops - o, 0);
        cmd(8'hD0);
        chk("R5", "erase count", ops - o, 1);
        chk("R11", "erase kind", last_kind, 6);
        chk("R5", "erase row", last_row, 'h1F30);
    endtask

    task automatic t_program;
        int o = ops, d = datas;
        cmd(8'h80); adr(8'h10); adr(8'h02); adr(8'h00);
        dat(8'hAA); dat(8'hBB);
        chk("R9", "data count", datas - d, 2);
        chk("R9", "last data col", last_dcol, 'h11);
        chk("R9", "last data byte", last_dbyte, 'hBB);
        cmd(8'h10);
        chk("R6", "program count", ops - o, 1);
        chk("R6", "program kind", last_kind, 5);
        chk("R6", "program col", last_col, 'h10);
        chk("R6", "program row", last_row, 2);
    endtask

    task automatic t_data_limit;
        int d = datas;
        cmd(8'h80); adr(8'hFE); adr(8'h00); adr(8'h00);
        for (int i = 0; i < 12; i++) dat(8'(i + 1));
        chk("R9", "bytes kept up to col 263", datas - d, 10);
        chk("R9", "last kept col", last_dcol, 263);
        chk("R9", "last kept byte", last_dbyte, 10);
        cmd(8'h10);
    endtask

    task automatic t_orphans;
        int o = ops, e = errs;
        cmd(8'hD0);
        chk("R7", "orphan erase confirm err", errs - e, 1);
        cmd(8'h10);
        chk("R7", "orphan program confirm err", errs - e, 2);
        chk("R7", "no op from orphans", ops - o, 0);
    endtask

    task automatic t_reset_cmd;
        int o = ops, e = errs;
        cmd(8'h60); adr(8'h11);
        cmd(8'hFF);
        chk("R8", "reset op count", ops - o, 1);
        chk("R8", "reset kind", last_kind, 4);
        cmd(8'hD0);
        chk("R8", "erase abandoned by reset", errs - e, 1);
        cmd(8'h80); cmd(8'h10);
        chk("R8", "program col after reset", last_col, 0);
        chk("R8", "program row after reset", last_row, 0);
    endtask

    task automatic t_status_mid_seq;
        int o = ops;
        cmd(8'h80); adr(8'h03); adr(8'h04); adr(8'h00);
        cmd(8'h70);
        chk("R10", "status fires", ops - o, 1);
        chk("R10", "status kind", last_kind, 7);
        cmd(8'h10);
        chk("R10", "program survives status", last_kind, 5);
        chk("R10", "program col after status", last_col, 3);
        chk("R10", "program row after status", last_row, 4);
    endtask

    bit finished = 0;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_read_main();
        t_read_spare();
        t_ignored_strobes();
        t_erase();
        t_program();
        t_data_limit();
        t_orphans();
        t_reset_cmd();
        t_status_mid_seq();
        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule